// File: doc/BRIEF.md
# Dual-Level Interrupt Routing Controller

This block collects level-sensitive interrupt lines from devices and delivers them to several processors. A line reaches a processor only after passing two gates: a global enable kept per source, and a mask kept per source for every processor. Software flips either gate by writing a source number to a dedicated set or clear register, so no read-modify-write of a bitmap is needed. Each shared source also has a routing word that selects which processors it may reach. The first 29 sources (0 to 28) are private to each processor and ignore routing. Source 0 carries the summary of the inter-processor doorbells, and source 1 carries the summary of the message-signalled doorbells.

Each processor has an acknowledge register. It returns the number of the lowest-numbered source that is pending, enabled, unmasked for that processor and, for a shared source, routed to it. It returns 1023 when no such source exists. A processor-select input picks whose mask window and acknowledge register a bus access touches. Addresses with bit 11 set form the per-processor window; all other addresses are global. Read data is registered and appears in the cycle after the read strobe. Each processor's interrupt output is combinational on the gate state and the source lines.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every global enable is 0, every per-processor mask is 1 (masked), every routing word is 0, every interrupt output is low and every acknowledge read returns 1023.
- R2: A write of value n to global address 0x030 sets the enable of source n. A write of n to 0x034 clears it.
- R3: A write of n to address 0x848 masks source n for the processor on `cpu_sel`. A write of n to 0x84C unmasks it. Other processors' masks are unchanged.
- R4: The routing word of source n is at 0x100 + 4*n. Bit c of the low 4 bits allows processor c; higher written bits are dropped. A read returns the stored bits with zeros above them.
- R5: A source numbered above 28 reaches processor c only if bit c of its routing word is 1. Sources 0 to 28 ignore the routing word.
- R6: A read of 0x844 returns, in bits [9:0], the lowest-numbered source that is eligible for the processor on `cpu_sel`, or 1023 if none is. Bits [31:10] read 0. Read data appears the cycle after `rd_en`.
- R7: A read of global address 0x000 returns the number of sources (64) in bits [11:2], which is the value 256.
- R8: A set or clear write whose value is 64 or greater changes no enable and no mask.
- R9: `irq_out[c]` is high exactly when at least one source is eligible for processor c. An eligible source is one whose line is high, whose enable is set, which is unmasked for c and, if it is shared, routed to c. The output follows the line level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | 64 | Level-sensitive device interrupt lines, bit n is source n |
| cpu_sel | input | 2 | Processor that the current bus access acts for |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after `rd_en` |
| irq_out | output | 4 | Interrupt request to each processor |

## Verification
The case hardest to reach from the ports is one where several sources are pending at once and the acknowledge value for each processor depends on its own mask and routing. A wrong priority order or a routing bit that is ignored only shows up then. The bench enables every source, unmasks all of them, gives each shared source a routing pattern that is different per processor, and raises a dense mix of lines. It then drops the reported source repeatedly and compares every acknowledge value with a model that walks the sources from 0 upward. A separate sweep visits all 64 sources one at a time. For shared sources it reads the acknowledge both before and after the routing bit is written, and it sends set and clear writes with out-of-range numbers that would wrap onto source 0 if the number were cut short.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // global register offsets
    localparam int unsigned CTRL_ADDR    = 'h000;
    localparam int unsigned EN_SET_ADDR  = 'h030;
    localparam int unsigned EN_CLR_ADDR  = 'h034;
    localparam int unsigned ROUTE_BASE   = 'h100;
    // per-processor window (bit 11 set)
    localparam int unsigned PCPU_BASE    = 'h800;
    localparam int unsigned ACK_ADDR     = PCPU_BASE + 'h044;
    localparam int unsigned MSK_SET_ADDR = PCPU_BASE + 'h048;
    localparam int unsigned MSK_CLR_ADDR = PCPU_BASE + 'h04C;
    // acknowledge code meaning "nothing pending"
    localparam logic [9:0]  NONE_CODE    = 10'd1023;
endpackage

// File: rtl/irq_gate_bank.sv
module irq_gate_bank #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 6,
    parameter int CPU_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en_set,
    input  logic                              en_clr,
    input  logic                              msk_set,
    input  logic                              msk_clr,
    input  logic [CPU_W-1:0]                  cpu_sel,
    input  logic [IDX_W-1:0]                  idx,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q
);
    // global enable: cleared at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (en_set) en_q[idx] <= 1'b1;
            if (en_clr) en_q[idx] <= 1'b0;
        end
    end

    // per-processor mask: all set at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msk_q <= '1;
        end else begin
            if (msk_set) msk_q[cpu_sel][idx] <= 1'b1;
            if (msk_clr) msk_q[cpu_sel][idx] <= 1'b0;
        end
    end

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en_q[$past(idx)]);
    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q[$past(idx)]);
    p_msk_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msk_set |=> msk_q[$past(cpu_sel)][$past(idx)]);
    p_msk_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msk_clr |=> !msk_q[$past(cpu_sel)][$past(idx)]);
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [NUM_CPU-1:0]                wbits,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (wr) begin
            route_q[idx] <= wbits;
        end
    end

    p_route_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> route_q[$past(idx)] == $past(wbits));
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               found,
    output logic [IDX_W-1:0]   pick
);
    // scan from the top down so that the lowest eligible index wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 4,
    parameter int PRIV_LAST = 28,
    parameter int ADDR_W    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          src_level,
    input  logic [$clog2(NUM_CPU)-1:0]  cpu_sel,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NUM_CPU-1:0]          irq_out
);
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int CPU_W      = $clog2(NUM_CPU);
    localparam int ROUTE_SPAN = 4 * NUM_SRC;

    // ---------------- address decode ----------------
    logic              hit_en_set, hit_en_clr, hit_msk_set, hit_msk_clr;
    logic              hit_ack, hit_ctrl, hit_route;
    logic              num_ok;
    logic [ADDR_W-1:0] route_off;
    logic [IDX_W-1:0]  route_idx;
    logic [IDX_W-1:0]  num_idx;

    always_comb begin
        hit_en_set  = (addr == ADDR_W'(EN_SET_ADDR));
        hit_en_clr  = (addr == ADDR_W'(EN_CLR_ADDR));
        hit_msk_set = (addr == ADDR_W'(MSK_SET_ADDR));
        hit_msk_clr = (addr == ADDR_W'(MSK_CLR_ADDR));
        hit_ack     = (addr == ADDR_W'(ACK_ADDR));
        hit_ctrl    = (addr == ADDR_W'(CTRL_ADDR));
        route_off   = addr - ADDR_W'(ROUTE_BASE);
        hit_route   = (addr >= ADDR_W'(ROUTE_BASE)) &&
                      (route_off < ADDR_W'(ROUTE_SPAN)) &&
                      (route_off[1:0] == 2'b00);
        route_idx   = route_off[IDX_W+1:2];
        num_ok      = (wdata < 32'(NUM_SRC));
        num_idx     = wdata[IDX_W-1:0];
    end

    // ---------------- gate state ----------------
    logic [NUM_SRC-1:0]               en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  msk_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q;

    irq_gate_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W),
        .CPU_W   (CPU_W)
    ) u_gates (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (wr_en && hit_en_set  && num_ok),
        .en_clr  (wr_en && hit_en_clr  && num_ok),
        .msk_set (wr_en && hit_msk_set && num_ok),
        .msk_clr (wr_en && hit_msk_clr && num_ok),
        .cpu_sel (cpu_sel),
        .idx     (num_idx),
        .en_q    (en_q),
        .msk_q   (msk_q)
    );

    irq_route_table #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W)
    ) u_routes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_en && hit_route),
        .idx     (route_idx),
        .wbits   (wdata[NUM_CPU-1:0]),
        .route_q (route_q)
    );

    // ---------------- eligibility and pick per processor ----------------
    logic [NUM_CPU-1:0][NUM_SRC-1:0] elig;
    logic [NUM_CPU-1:0][IDX_W-1:0]   pick;
    logic [NUM_CPU-1:0][9:0]         ack_code;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            if (n <= PRIV_LAST) begin : g_private
                assign elig[c][n] = src_level[n] & en_q[n] & ~msk_q[c][n];
            end else begin : g_shared
                assign elig[c][n] = src_level[n] & en_q[n] & ~msk_q[c][n]
                                    & route_q[n][c];
            end
        end

        irq_lowest_pick #(
            .NUM_SRC (NUM_SRC),
            .IDX_W   (IDX_W)
        ) u_pick (
            .elig  (elig[c]),
            .found (irq_out[c]),
            .pick  (pick[c])
        );

        assign ack_code[c] = irq_out[c] ? 10'(pick[c]) : NONE_CODE;
    end

    // ---------------- read path ----------------
    logic [31:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux = 32'(NUM_SRC) << 2;
        end else if (hit_ack) begin
            rd_mux = {22'd0, ack_code[cpu_sel]};
        end else if (hit_route) begin
            rd_mux = 32'(route_q[route_idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    // ---------------- assertions ----------------
    p_ack_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ack) |=> ((rdata == 32'd1023) == !$past(irq_out[cpu_sel])));
    p_ack_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ack) |=> (rdata < 32'(NUM_SRC)) || (rdata == 32'd1023));
    p_oor_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !num_ok && (hit_en_set || hit_en_clr || hit_msk_set || hit_msk_clr))
        |=> ($stable(en_q) && $stable(msk_q)));
    p_no_enable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (irq_out == '0));
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_level = '0;
    logic [1:0]  cpu_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model of the gate state
    bit       en_m [64];
    bit       mk_m [4][64];
    bit [3:0] rt_m [64];

    always #10 clk = ~clk;  // 50 MHz

    irq_route_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .cpu_sel   (cpu_sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input int c);
        @(negedge clk);
        addr = a; wdata = d; cpu_sel = c[1:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input int c, output logic [31:0] q);
        @(negedge clk);
        addr = a; cpu_sel = c[1:0]; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    // model-updating helpers
    task automatic en_set(input int n);   bus_wr(12'h030, n, 0); if (n < 64) en_m[n] = 1'b1; endtask
    task automatic en_clr(input int n);   bus_wr(12'h034, n, 0); if (n < 64) en_m[n] = 1'b0; endtask
    task automatic mk_set(input int n, input int c); bus_wr(12'h848, n, c); if (n < 64) mk_m[c][n] = 1'b1; endtask
    task automatic mk_clr(input int n, input int c); bus_wr(12'h84C, n, c); if (n < 64) mk_m[c][n] = 1'b0; endtask
    task automatic rt_wr(input int n, input logic [31:0] v);
        bus_wr(12'(32'h100 + 4 * n), v, 0);
        rt_m[n] = v[3:0];
    endtask

    function automatic int exp_ack(input int c);
        for (int n = 0; n < 64; n++) begin
            if (src_level[n] && en_m[n] && !mk_m[c][n] && (n <= 28 || rt_m[n][c]))
                return n;
        end
        return 1023;
    endfunction

    // R6 and R9 against the model for every processor
    task automatic check_all(input string req);
        logic [31:0] q;
        for (int c = 0; c < 4; c++) begin
            bus_rd(12'h844, c, q);
            chk({req, " ack R6"}, q, exp_ack(c));
            chk({req, " irq_out R9"}, irq_out[c], exp_ack(c) != 1023);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        for (int n = 0; n < 64; n++) begin
            en_m[n] = 1'b0; rt_m[n] = '0;
            for (int c = 0; c < 4; c++) mk_m[c][n] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // ---- reset state: R1, R7 ----
        bus_rd(12'h000, 0, q);
        chk("R7 source count", q, 256);
        chk("R1 irq_out after reset", irq_out, 0);
        bus_rd(12'h114, 0, q);
        chk("R1 route word after reset", q, 0);
        src_level = '1;
        check_all("R1 reset all lines high");
        en_set(40); rt_wr(40, 32'h1);
        check_all("R1 masks start set");
        en_clr(40); rt_wr(40, 32'h0);
        src_level = '0;

        // ---- single-source sweep: R2, R3, R5 ----
        for (int n = 0; n < 64; n++) begin
            int tc;
            tc = n % 4;
            src_level = 64'd1 << n;
            en_set(n);
            mk_clr(n, tc);
            if (n > 28) begin
                check_all("R5 shared without route");
                rt_wr(n, 32'(1 << tc));
            end
            check_all("R2 R3 R5 single source delivered");
            en_clr(n);
            check_all("R2 enable cleared");
            en_set(n);
            mk_set(n, tc);
            check_all("R3 mask set again");
            en_clr(n);
            rt_wr(n, 32'h0);
        end
        src_level = '0;

        // ---- route word readback: R4 ----
        for (int n = 0; n < 64; n++) rt_wr(n, 32'hFFFF_FFF0 | 32'((n * 7) & 15));
        for (int n = 0; n < 64; n++) begin
            bus_rd(12'(32'h100 + 4 * n), 0, q);
            chk("R4 route readback", q, (n * 7) & 15);
        end

        // ---- out-of-range numbers: R8 ----
        src_level = 64'h1;
        bus_wr(12'h030, 64, 0);
        bus_wr(12'h030, 32'hFFFF_FFC0, 0);
        bus_wr(12'h84C, 64, 1);
        bus_wr(12'h84C, 128, 1);
        check_all("R8 out-of-range set/unmask ignored");
        en_set(0); mk_clr(0, 1);
        check_all("R8 source 0 via in-range path");
        bus_wr(12'h034, 64, 0);
        bus_wr(12'h848, 64, 1);
        check_all("R8 out-of-range clear/mask ignored");
        en_clr(0); mk_set(0, 1);

        // ---- priority with many pending: R6, R5 ----
        for (int n = 0; n < 64; n++) begin
            en_set(n);
            for (int c = 0; c < 4; c++) mk_clr(n, c);
        end
        src_level = 64'hA5F0_3C96_C000_0000;
        check_all("R6 dense shared only");
        src_level = 64'h5A0F_C369_1248_8421;
        for (int k = 0; k < 20; k++) begin
            int lo;
            check_all("R6 lowest first");
            lo = exp_ack(k % 4);
            if (lo != 1023) src_level[lo] = 1'b0;
        end
        // per-CPU mask affects only that CPU
        src_level = 64'h0000_0000_0000_0030;
        mk_set(4, 2);
        check_all("R3 mask on one processor only");

        // level drop follows immediately
        src_level = '0;
        @(negedge clk);
        chk("R9 lines low", irq_out, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule